// File: doc/BRIEF.md
# Single-Bit Boolean Operation Unit

This unit carries out one-bit operations on bytes held in data memory and on a carry flag that it owns. A request names an operation, a 16-bit operand word, an 8-bit accumulator value, a direct-page control byte and a page select. The unit reads the target byte through a synchronous memory port. Carry operations then fold the selected bit into the carry. Read-modify-write operations compute a new byte and write it back to the same address in the next cycle.

Absolute bit operations split the operand into a 13-bit byte address and a bit index held in its top three bits. Direct-page set and clear take the bit index and the set/clear choice from the control byte, and form the address from the low operand byte plus a page base. The accumulator-mask operations update N and Z from a subtraction and then set or clear the accumulator's bits in memory. Every operation ends with a one-cycle done pulse.

Top module: `bitop_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `c_flag`, `n_flag`, `z_flag`, `done`, `mem_re` and `mem_we` are all 0.
- R2: For the absolute bit operations (op codes 0 to 7), the memory address is operand[12:0] zero-extended to 16 bits, and the bit index is operand[15:13].
- R3: The carry logic ops use these codes: 0 gives C AND bit, 1 gives C AND NOT bit, 2 gives C OR bit, 3 gives C OR NOT bit, and 4 gives C XOR bit. The new carry appears at `c_flag` together with `done`.
- R4: Op 5 loads the carry from the selected bit. It performs no write.
- R5: Op 7 writes the byte back to the address it read, with only the selected bit inverted.
- R6: Op 6 writes the byte back to the address it read, with the selected bit replaced by the carry.
- R7: For op 8 (direct-page bit), `dp_ctl[7:5]` is the bit index. `dp_ctl[4]`=1 clears the bit and 0 sets it. The address is `{7'b0, dp_page, operand[7:0]}`.
- R8: Op 9 and op 10 read the byte at the full 16-bit operand. Both set N to bit 7 of (acc − byte) mod 256 and set Z when that result is zero. Op 9 writes byte OR acc, and op 10 writes byte AND NOT acc.
- R9: The edge that accepts `start` is followed by a cycle with `mem_re`=1. In the next cycle `mem_we`=1 for ops 6 to 10 and 0 for ops 0 to 5. `done` is high for exactly one cycle after that.
- R10: Flags an operation does not affect keep their values. Ops 0 to 5 change only C, ops 9 and 10 change only N and Z, and ops 6 to 8 change none. No flag changes outside the `done` cycle.
- R11: A `start` that arrives while an operation is in progress is ignored. It causes no extra memory access and no extra `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| op | input | 4 | Operation code |
| operand | input | 16 | Operand word |
| acc | input | 8 | Accumulator value for mask operations |
| dp_ctl | input | 8 | Direct-page control: bit index [7:5], clear [4] |
| dp_page | input | 1 | Direct-page base select (0x000 or 0x100) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| c_flag | output | 1 | Carry flag |
| n_flag | output | 1 | Negative flag |
| z_flag | output | 1 | Zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses operands whose address bits and index bits both matter. A design that swapped or truncated the split would read the wrong byte or test the wrong bit. The carry ops run with the carry both set and clear, so a missing inversion in the inverted-bit forms shows up as a wrong carry. Direct-page operations run on both pages and in both set and clear forms, which catches a dropped page bit or a reversed clear flag. The mask operations run with equal values for Z and with acc below memory for N. Flag values are checked in every cycle of every operation, so a design that disturbed an unrelated flag or updated a flag early would be reported. A second start held through a busy operation would show up as an extra read or done pulse.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int BYTE_AW    = 13;
    localparam int IDX_W      = $clog2(DATA_W);
    localparam int OP_W       = 4;
    localparam int DP_BASE_W  = 1;
    localparam int PAD_W      = ADDR_W - DATA_W - DP_BASE_W;

    typedef enum logic [OP_W-1:0] {
        OP_AND   = 4'd0,
        OP_ANDN  = 4'd1,
        OP_OR    = 4'd2,
        OP_ORN   = 4'd3,
        OP_EOR   = 4'd4,
        OP_LDC   = 4'd5,
        OP_STC   = 4'd6,
        OP_NOT   = 4'd7,
        OP_DPBIT = 4'd8,
        OP_TSET  = 4'd9,
        OP_TCLR  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_EXE  = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic              rmw;
        logic              clr;
    } target_t;

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic              c;
        logic              n;
        logic              z;
        logic              c_we;
        logic              nz_we;
    } alu_out_t;

    function automatic logic [DATA_W-1:0] one_hot(input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    function automatic logic is_rmw(input op_e op);
        return (op == OP_STC) || (op == OP_NOT) || (op == OP_DPBIT) ||
               (op == OP_TSET) || (op == OP_TCLR);
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  op_e                  op,
    input  logic [ADDR_W-1:0]    operand,
    input  logic [DATA_W-1:0]    dp_ctl,
    input  logic                 dp_page,
    output target_t              tgt
);
    always_comb begin
        tgt.rmw = is_rmw(op);
        tgt.clr = dp_ctl[DATA_W-1-IDX_W];
        unique case (op)
            OP_DPBIT: begin
                tgt.addr = {{PAD_W{1'b0}}, dp_page, operand[DATA_W-1:0]};
                tgt.idx  = dp_ctl[DATA_W-1 -: IDX_W];
            end
            OP_TSET, OP_TCLR: begin
                tgt.addr = operand;
                tgt.idx  = '0;
            end
            default: begin
                tgt.addr = {{(ADDR_W-BYTE_AW){1'b0}}, operand[BYTE_AW-1:0]};
                tgt.idx  = operand[ADDR_W-1 -: IDX_W];
            end
        endcase
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
(
    input  op_e                  op,
    input  target_t              tgt,
    input  logic [DATA_W-1:0]    rdata,
    input  logic [DATA_W-1:0]    acc,
    input  logic                 c_in,
    output alu_out_t             res
);
    logic [DATA_W-1:0] mask;
    logic              sel_bit;
    logic [DATA_W-1:0] diff;

    always_comb begin
        mask    = one_hot(tgt.idx);
        sel_bit = |(rdata & mask);
        diff    = acc - rdata;

        res       = '0;
        res.wdata = rdata;
        res.c     = c_in;

        unique case (op)
            OP_AND:  begin res.c = c_in &  sel_bit; res.c_we = 1'b1; end
            OP_ANDN: begin res.c = c_in & ~sel_bit; res.c_we = 1'b1; end
            OP_OR:   begin res.c = c_in |  sel_bit; res.c_we = 1'b1; end
            OP_ORN:  begin res.c = c_in | ~sel_bit; res.c_we = 1'b1; end
            OP_EOR:  begin res.c = c_in ^  sel_bit; res.c_we = 1'b1; end
            OP_LDC:  begin res.c = sel_bit;         res.c_we = 1'b1; end
            OP_STC:  res.wdata = c_in ? (rdata | mask) : (rdata & ~mask);
            OP_NOT:  res.wdata = rdata ^ mask;
            OP_DPBIT: res.wdata = tgt.clr ? (rdata & ~mask) : (rdata | mask);
            OP_TSET, OP_TCLR: begin
                res.wdata = (op == OP_TSET) ? (rdata | acc) : (rdata & ~acc);
                res.n     = diff[DATA_W-1];
                res.z     = (diff == '0);
                res.nz_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  op,
    input  logic [15:0] operand,
    input  logic [7:0]  acc,
    input  logic [7:0]  dp_ctl,
    input  logic        dp_page,
    output logic        mem_re,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        c_flag,
    output logic        n_flag,
    output logic        z_flag,
    output logic        done
);
    state_e            state;
    op_e               op_q;
    logic [ADDR_W-1:0] operand_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] dp_ctl_q;
    logic              dp_page_q;
    target_t           tgt;
    alu_out_t          res;

    bitop_decode u_dec (
        .op      (op_q),
        .operand (operand_q),
        .dp_ctl  (dp_ctl_q),
        .dp_page (dp_page_q),
        .tgt     (tgt)
    );

    bitop_alu u_alu (
        .op    (op_q),
        .tgt   (tgt),
        .rdata (mem_rdata),
        .acc   (acc_q),
        .c_in  (c_flag),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= OP_AND;
            operand_q <= '0;
            acc_q     <= '0;
            dp_ctl_q  <= '0;
            dp_page_q <= 1'b0;
            c_flag    <= 1'b0;
            n_flag    <= 1'b0;
            z_flag    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_RD;
                    op_q      <= op_e'(op);
                    operand_q <= operand;
                    acc_q     <= acc;
                    dp_ctl_q  <= dp_ctl;
                    dp_page_q <= dp_page;
                end
                ST_RD:   state <= ST_EXE;
                ST_EXE: begin
                    state <= ST_DONE;
                    if (res.c_we) c_flag <= res.c;
                    if (res.nz_we) begin
                        n_flag <= res.n;
                        z_flag <= res.z;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_re    = (state == ST_RD);
    assign mem_we    = (state == ST_EXE) && tgt.rmw;
    assign mem_addr  = tgt.addr;
    assign mem_wdata = res.wdata;
    assign done      = (state == ST_DONE);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_WE_AFTER_RE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(mem_re)); // R9
    AST_RE_WE_APART: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R9
    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_re, 2)); // R9
    AST_WADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $stable(mem_addr)); // R5
    AST_C_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(c_flag) |-> done); // R10
    AST_NZ_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(n_flag) || !$stable(z_flag)) |-> done); // R10

endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] operand = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  dp_ctl = '0;
    logic        dp_page = 1'b0;
    logic        mem_re, mem_we, c_flag, n_flag, z_flag, done;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int tests = 0;
    int fails = 0;

    logic [7:0] mem     [0:8191];
    logic [7:0] ref_mem [0:8191];
    logic ref_c = 1'b0, ref_n = 1'b0, ref_z = 1'b0;

    always #5 clk = ~clk;

    bitop_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .operand(operand),
        .acc(acc), .dp_ctl(dp_ctl), .dp_page(dp_page),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .c_flag(c_flag), .n_flag(n_flag), .z_flag(z_flag), .done(done)
    );

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[12:0]];
        if (mem_we) mem[mem_addr[12:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({c_flag, n_flag, z_flag} == {ref_c, ref_n, ref_z}, req, "flags CNZ",
            {c_flag, n_flag, z_flag}, {ref_c, ref_n, ref_z});
    endtask

    task automatic do_op(input int opc, input logic [15:0] opnd, input logic [7:0] a,
                         input logic [7:0] dpc, input logic dpp, input bit poke,
                         input string req);
        logic [15:0] ea;
        int          idx;
        bit          rmw;
        logic [7:0]  old, nw;
        logic        b, nc, nn, nz;
        logic [7:0]  df;
        if (opc == 8) begin
            ea = {7'd0, dpp, opnd[7:0]}; idx = dpc[7:5];
        end else if (opc >= 9) begin
            ea = opnd; idx = 0;
        end else begin
            ea = {3'd0, opnd[12:0]}; idx = opnd[15:13];
        end
        old = ref_mem[ea[12:0]];
        b   = old[idx];
        nw  = old; nc = ref_c; nn = ref_n; nz = ref_z;
        rmw = (opc >= 6);
        case (opc)
            0: nc = ref_c & b;
            1: nc = ref_c & !b;
            2: nc = ref_c | b;
            3: nc = ref_c | !b;
            4: nc = ref_c ^ b;
            5: nc = b;
            6: nw[idx] = ref_c;
            7: nw[idx] = !b;
            8: nw[idx] = !dpc[4];
            default: begin
                df = a - old;
                nn = df[7];
                nz = (df == 8'd0);
                nw = (opc == 9) ? (old | a) : (old & ~a);
            end
        endcase

        @(negedge clk);
        start = 1'b1; op = opc[3:0]; operand = opnd; acc = a; dp_ctl = dpc; dp_page = dpp;
        @(negedge clk);
        if (poke) begin
            op = 4'd7; operand = opnd ^ 16'h0155; dp_page = !dpp;
        end else start = 1'b0;
        chk(mem_re == 1'b1, "R9", "read cycle mem_re", mem_re, 1);
        chk(mem_addr == ea, (opc == 8) ? "R7" : ((opc >= 9) ? "R8" : "R2"),
            "read address", mem_addr, ea);
        chk(mem_we == 1'b0 && done == 1'b0, "R9", "no write/done in read cycle",
            {mem_we, done}, 0);
        chk_flags("R10");
        @(negedge clk);
        start = 1'b0;
        chk(mem_re == 1'b0, "R9", "second cycle mem_re", mem_re, 0);
        chk(mem_we == rmw, "R9", "write strobe", mem_we, rmw);
        if (rmw) begin
            chk(mem_wdata == nw, req, "write data", mem_wdata, nw);
            chk(mem_addr == ea, "R5", "write address", mem_addr, ea);
        end
        chk(done == 1'b0, "R9", "done early", done, 0);
        chk_flags("R10");
        ref_c = nc; ref_n = nn; ref_z = nz;
        ref_mem[ea[12:0]] = nw;
        @(negedge clk);
        chk(done == 1'b1, "R9", "done pulse", done, 1);
        chk({c_flag, n_flag, z_flag} == {ref_c, ref_n, ref_z}, req, "result flags CNZ",
            {c_flag, n_flag, z_flag}, {ref_c, ref_n, ref_z});
        @(negedge clk);
        chk(done == 1'b0 && mem_re == 1'b0 && mem_we == 1'b0, poke ? "R11" : "R9",
            "idle after done", {done, mem_re, mem_we}, 0);
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) begin
            mem[i]     = 8'((i * 37 + 5) & 255);
            ref_mem[i] = 8'((i * 37 + 5) & 255);
        end
        mem[13'h0123] = 8'hA5; ref_mem[13'h0123] = 8'hA5;
        mem[13'h1F40] = 8'h3C; ref_mem[13'h1F40] = 8'h3C;
        mem[13'h0042] = 8'h00; ref_mem[13'h0042] = 8'h00;
        mem[13'h0142] = 8'hFF; ref_mem[13'h0142] = 8'hFF;
        mem[13'h0777] = 8'h5A; ref_mem[13'h0777] = 8'h5A;
        repeat (3) @(negedge clk);
        chk({c_flag, n_flag, z_flag, done, mem_re, mem_we} == 6'd0, "R1",
            "outputs in reset", {c_flag, n_flag, z_flag, done, mem_re, mem_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({c_flag, n_flag, z_flag, done, mem_re, mem_we} == 6'd0, "R1",
            "outputs after reset", {c_flag, n_flag, z_flag, done, mem_re, mem_we}, 0);

        // R4: load carry; 0xA5 = 1010_0101, bit 0 set, bit 1 clear
        do_op(5, {3'd0, 13'h0123}, 8'h00, 8'h00, 1'b0, 0, "R4");
        do_op(5, {3'd1, 13'h0123}, 8'h00, 8'h00, 1'b0, 0, "R4");
        do_op(5, {3'd7, 13'h0123}, 8'h00, 8'h00, 1'b0, 0, "R4");
        // R3: carry logic with both carry states; 0x3C bits 2..5 set
        do_op(0, {3'd2, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(1, {3'd2, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(3, {3'd2, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(3, {3'd0, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(4, {3'd3, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(2, {3'd6, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(2, {3'd5, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(1, {3'd7, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(0, {3'd6, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        do_op(4, {3'd4, 13'h1F40}, 8'h00, 8'h00, 1'b0, 0, "R3");
        // R5: toggle; R6: store carry (carry 1 then 0)
        do_op(7, {3'd6, 13'h0777}, 8'h00, 8'h00, 1'b0, 0, "R5");
        do_op(7, {3'd1, 13'h0777}, 8'h00, 8'h00, 1'b0, 0, "R5");
        do_op(6, {3'd0, 13'h0777}, 8'h00, 8'h00, 1'b0, 0, "R6");
        do_op(5, {3'd0, 13'h0042}, 8'h00, 8'h00, 1'b0, 0, "R4");
        do_op(6, {3'd4, 13'h0777}, 8'h00, 8'h00, 1'b0, 0, "R6");
        // R7: direct-page set/clear on both pages
        do_op(8, 16'hFF42, 8'h00, 8'b1010_0000, 1'b0, 0, "R7");
        do_op(8, 16'h0042, 8'h00, 8'b0111_0000, 1'b1, 0, "R7");
        do_op(8, 16'h0042, 8'h00, 8'b1011_0000, 1'b0, 0, "R7");
        // R8: mask ops; equal gives Z, acc below memory gives N
        do_op(9, 16'h0123, 8'hA5, 8'h00, 1'b0, 0, "R8");
        do_op(9, 16'h1F40, 8'h01, 8'h00, 1'b0, 0, "R8");
        do_op(10, 16'h0777, 8'h0F, 8'h00, 1'b0, 0, "R8");
        // R11: start held during a busy operation
        do_op(7, {3'd3, 13'h0777}, 8'h00, 8'h00, 1'b0, 1, "R11");
        do_op(5, {3'd3, 13'h0777}, 8'h00, 8'h00, 1'b0, 1, "R11");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule